// File: doc/BRIEF.md
# Processor Sleep State Sequencer

This block drives the three active-low handshake lines that put a host processor into its low-power idle states and bring it back out. A read strobe on the shallow-sleep level register moves the processor from normal running (C0) into a stop-clock state (C2). A read strobe on the deep-sleep level register moves it into a suspend state (C3). A halt event records the software-controlled halt state (C1), which drives no handshake line. A single-cycle break event starts the return to C0.

Leaving C3 follows a fixed order. When the host-stop option was set on entry, the CPU-stop line is released first. A programmable down-counter then lets the processor PLL regain lock. Only after that are the suspend-status and stop-clock lines released, both on the same edge. When host-stop was clear on entry, CPU-stop was never asserted, so the lock wait is skipped.

Top module: `proc_sleep_seq`

## Requirements
- R1: After reset, stpclk_n_o, cpustp_n_o and susst_n_o are 1 and state_o is 0 (encoding: C0=0, C1=1, C2=2, C3=3).
- R2: In C0, a lvl2_rd_i pulse sets state_o to 2 on the next cycle, with stpclk_n_o=0, cpustp_n_o=1 and susst_n_o=1.
- R3: In C2, a break_i pulse sets state_o to 0 and stpclk_n_o to 1 on the next cycle.
- R4: In C0, a lvl3_rd_i pulse sets state_o to 3 on the next cycle, with stpclk_n_o=0 and susst_n_o=0. cpustp_n_o becomes 0 only if host_stop_en_i was 1 at that strobe. Later changes of host_stop_en_i do not alter this.
- R5: In C3 entered with host-stop set, a break_i pulse raises cpustp_n_o on the next cycle. susst_n_o and stpclk_n_o then rise together exactly lock_dly_i+1 cycles after cpustp_n_o, using the lock_dly_i value sampled with the break. state_o stays 3 until that release and reads 0 afterwards.
- R6: In C3 entered with host-stop clear, a break_i pulse raises susst_n_o and stpclk_n_o and sets state_o to 0 on the next cycle.
- R7: In C0, a halt_i pulse sets state_o to 1 and leaves all three handshake lines at 1. A break_i pulse in C1 returns state_o to 0.
- R8: lvl2_rd_i, lvl3_rd_i and halt_i are ignored outside C0. break_i is ignored in C0 and during the PLL-lock wait.
- R9: When strobes coincide in C0, lvl3_rd_i takes priority over lvl2_rd_i, which takes priority over halt_i.
- R10: cpustp_n_o is never 0 unless stpclk_n_o and susst_n_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl2_rd_i | input | 1 | One-cycle strobe: shallow-sleep level register was read |
| lvl3_rd_i | input | 1 | One-cycle strobe: deep-sleep level register was read |
| halt_i | input | 1 | One-cycle strobe: software halt entered |
| break_i | input | 1 | One-cycle wake/break event |
| host_stop_en_i | input | 1 | Enables CPU-stop assertion in C3 |
| lock_dly_i | input | LOCK_W | PLL lock wait, in cycles (plus one) |
| stpclk_n_o | output | 1 | Stop-clock request, active low |
| cpustp_n_o | output | 1 | CPU clock-stop, active low |
| susst_n_o | output | 1 | Suspend status to the memory controller, active low |
| state_o | output | 2 | Current processor state (C0=0, C1=1, C2=2, C3=3) |

## Verification
The bench sweeps the lock delay over 0 to 6 and two larger values. For each value it counts the exact cycle gap between the CPU-stop release and the joint release. A design with an off-by-one counter, or one that releases stop-clock early, produces a wrong count. It enters C3 with host-stop both set and clear, then toggles the enable during C3. A design that reads the live bit instead of the captured one either waits when it should not or drops CPU-stop mid-state. It also issues strobes in every non-C0 state, a break during the lock wait and coincident strobes. A design that forgets to gate these falls into the wrong state, or releases the lines out of order.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        PH_RUN  = 3'd0,
        PH_HALT = 3'd1,
        PH_STOP = 3'd2,
        PH_SUSP = 3'd3,
        PH_LOCK = 3'd4
    } phase_e;

    localparam logic [1:0] ST_C0 = 2'd0;
    localparam logic [1:0] ST_C1 = 2'd1;
    localparam logic [1:0] ST_C2 = 2'd2;
    localparam logic [1:0] ST_C3 = 2'd3;

    typedef struct packed {
        phase_e phase;
        logic   stpclk_n;
        logic   cpustp_n;
        logic   susst_n;
        logic   hs_cap;
    } seq_s;

endpackage

// File: rtl/sleep_lock_timer.sv
module sleep_lock_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl2_rd_i,
    input  logic       lvl3_rd_i,
    input  logic       halt_i,
    input  logic       break_i,
    input  logic       host_stop_en_i,
    input  logic       tmr_zero_i,
    output logic       tmr_load_o,
    output logic       stpclk_n_o,
    output logic       cpustp_n_o,
    output logic       susst_n_o,
    output logic [1:0] state_o
);
    seq_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        tmr_load_o = 1'b0;
        unique case (s_q.phase)
            PH_RUN: begin
                if (lvl3_rd_i) begin
                    s_d.phase    = PH_SUSP;
                    s_d.stpclk_n = 1'b0;
                    s_d.susst_n  = 1'b0;
                    s_d.cpustp_n = ~host_stop_en_i;
                    s_d.hs_cap   = host_stop_en_i;
                end else if (lvl2_rd_i) begin
                    s_d.phase    = PH_STOP;
                    s_d.stpclk_n = 1'b0;
                end else if (halt_i) begin
                    s_d.phase = PH_HALT;
                end
            end
            PH_HALT: begin
                if (break_i) s_d.phase = PH_RUN;
            end
            PH_STOP: begin
                if (break_i) begin
                    s_d.phase    = PH_RUN;
                    s_d.stpclk_n = 1'b1;
                end
            end
            PH_SUSP: begin
                if (break_i) begin
                    if (s_q.hs_cap) begin
                        s_d.phase    = PH_LOCK;
                        s_d.cpustp_n = 1'b1;
                        tmr_load_o   = 1'b1;
                    end else begin
                        s_d.phase    = PH_RUN;
                        s_d.stpclk_n = 1'b1;
                        s_d.susst_n  = 1'b1;
                    end
                end
            end
            PH_LOCK: begin
                if (tmr_zero_i) begin
                    s_d.phase    = PH_RUN;
                    s_d.stpclk_n = 1'b1;
                    s_d.susst_n  = 1'b1;
                    s_d.hs_cap   = 1'b0;
                end
            end
            default: s_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase    <= PH_RUN;
            s_q.stpclk_n <= 1'b1;
            s_q.cpustp_n <= 1'b1;
            s_q.susst_n  <= 1'b1;
            s_q.hs_cap   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.phase)
            PH_HALT:          state_o = ST_C1;
            PH_STOP:          state_o = ST_C2;
            PH_SUSP, PH_LOCK: state_o = ST_C3;
            default:          state_o = ST_C0;
        endcase
    end

    assign stpclk_n_o = s_q.stpclk_n;
    assign cpustp_n_o = s_q.cpustp_n;
    assign susst_n_o  = s_q.susst_n;
endmodule

// File: rtl/proc_sleep_seq.sv
module proc_sleep_seq #(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl2_rd_i,
    input  logic              lvl3_rd_i,
    input  logic              halt_i,
    input  logic              break_i,
    input  logic              host_stop_en_i,
    input  logic [LOCK_W-1:0] lock_dly_i,
    output logic              stpclk_n_o,
    output logic              cpustp_n_o,
    output logic              susst_n_o,
    output logic [1:0]        state_o
);
    logic tmr_load, tmr_zero;

    sleep_seq_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .lvl2_rd_i      (lvl2_rd_i),
        .lvl3_rd_i      (lvl3_rd_i),
        .halt_i         (halt_i),
        .break_i        (break_i),
        .host_stop_en_i (host_stop_en_i),
        .tmr_zero_i     (tmr_zero),
        .tmr_load_o     (tmr_load),
        .stpclk_n_o     (stpclk_n_o),
        .cpustp_n_o     (cpustp_n_o),
        .susst_n_o      (susst_n_o),
        .state_o        (state_o)
    );

    sleep_lock_timer #(.W(LOCK_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (lock_dly_i),
        .zero_o (tmr_zero)
    );
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       break_i,
    input logic       stpclk_n_o,
    input logic       cpustp_n_o,
    input logic       susst_n_o,
    input logic [1:0] state_o
);
    // R1
    c0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> (stpclk_n_o && cpustp_n_o && susst_n_o));

    // R2
    c2_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (!stpclk_n_o && cpustp_n_o && susst_n_o));

    // R3
    c2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && break_i) |=> (state_o == 2'd0 && stpclk_n_o));

    // R5
    lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpustp_n_o) |-> !stpclk_n_o);

    // R5
    joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susst_n_o) |-> $rose(stpclk_n_o));

    // R7
    c1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (stpclk_n_o && cpustp_n_o && susst_n_o));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && !break_i) |=> (state_o == 2'd1));

    // R10
    cpustp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpustp_n_o |-> (!stpclk_n_o && !susst_n_o));
endmodule

bind proc_sleep_seq sleep_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .break_i    (break_i),
    .stpclk_n_o (stpclk_n_o),
    .cpustp_n_o (cpustp_n_o),
    .susst_n_o  (susst_n_o),
    .state_o    (state_o)
);

// File: tb/proc_sleep_seq_tb_top.sv
module proc_sleep_seq_tb_top;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lvl2 = 1'b0, lvl3 = 1'b0, halt = 1'b0, brk = 1'b0, hs = 1'b0;
    logic [LW-1:0] dly = '0;
    logic          stpclk_n, cpustp_n, susst_n;
    logic [1:0]    state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    proc_sleep_seq #(.LOCK_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lvl2_rd_i(lvl2), .lvl3_rd_i(lvl3), .halt_i(halt), .break_i(brk),
        .host_stop_en_i(hs), .lock_dly_i(dly),
        .stpclk_n_o(stpclk_n), .cpustp_n_o(cpustp_n), .susst_n_o(susst_n),
        .state_o(state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit l2, input bit l3, input bit h, input bit b);
        @(negedge clk);
        lvl2 = l2; lvl3 = l3; halt = h; brk = b;
        @(negedge clk);
        lvl2 = 0; lvl3 = 0; halt = 0; brk = 0;
    endtask

    task automatic lines(input string tag, input int st, input int sc, input int cs, input int ss);
        chk({tag, " state"}, int'(state), st);
        chk({tag, " stpclk_n"}, int'(stpclk_n), sc);
        chk({tag, " cpustp_n"}, int'(cpustp_n), cs);
        chk({tag, " susst_n"}, int'(susst_n), ss);
    endtask

    task automatic deep_cycle(input int n, input bit inject);
        int k;
        hs = 1;
        dly = LW'(n);
        pulse(0, 1, 0, 0);
        lines("R4 hs=1 entry", 3, 0, 0, 0);
        pulse(0, 0, 0, 1);
        dly = '0;
        lines("R5 cpustp first", 3, 0, 1, 0);
        k = 0;
        while (stpclk_n == 1'b0 && k < 2000) begin
            brk = (inject && k == 1) ? 1'b1 : 1'b0;
            @(negedge clk);
            k++;
            if (stpclk_n == 1'b0) chk("R5 state held during wait", int'(state), 3);
        end
        brk = 0;
        chk($sformatf("R5 lock gap n=%0d", n), k, n + 1);
        lines("R5 joint release", 0, 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lines("R1 reset", 0, 1, 1, 1);

        pulse(1, 0, 0, 0);
        lines("R2 C2 entry", 2, 0, 1, 1);
        pulse(0, 1, 0, 0);
        lines("R8 lvl3 in C2", 2, 0, 1, 1);
        pulse(0, 0, 1, 0);
        chk("R8 halt in C2", int'(state), 2);
        pulse(0, 0, 0, 1);
        lines("R3 C2 exit", 0, 1, 1, 1);

        pulse(0, 0, 0, 1);
        lines("R8 break in C0", 0, 1, 1, 1);

        pulse(0, 0, 1, 0);
        lines("R7 C1 entry", 1, 1, 1, 1);
        pulse(1, 0, 0, 0);
        lines("R8 lvl2 in C1", 1, 1, 1, 1);
        pulse(0, 1, 0, 0);
        lines("R8 lvl3 in C1", 1, 1, 1, 1);
        pulse(0, 0, 0, 1);
        lines("R7 C1 exit", 0, 1, 1, 1);

        hs = 0;
        dly = 16'd9;
        pulse(0, 1, 0, 0);
        lines("R4 hs=0 entry", 3, 0, 1, 0);
        hs = 1;
        repeat (3) @(negedge clk);
        lines("R4 live hs ignored", 3, 0, 1, 0);
        pulse(1, 0, 1, 0);
        lines("R8 strobes in C3", 3, 0, 1, 0);
        pulse(0, 0, 0, 1);
        lines("R6 no-wait exit", 0, 1, 1, 1);

        for (int n = 0; n <= 6; n++) deep_cycle(n, 1'b0);
        deep_cycle(37, 1'b1);
        deep_cycle(300, 1'b0);

        hs = 1;
        dly = 16'd2;
        pulse(0, 1, 0, 0);
        hs = 0;
        repeat (2) @(negedge clk);
        lines("R4 captured hs kept", 3, 0, 0, 0);
        pulse(0, 0, 0, 1);
        lines("R5 wait after hs drop", 3, 0, 1, 0);
        repeat (3) @(negedge clk);
        lines("R5 wait done", 0, 1, 1, 1);

        pulse(1, 1, 1, 0);
        lines("R9 lvl3 wins", 3, 0, 1, 0);
        pulse(0, 0, 0, 1);
        pulse(1, 0, 1, 0);
        lines("R9 lvl2 over halt", 2, 0, 1, 1);
        pulse(0, 0, 0, 1);
        chk("R3 final exit", int'(state), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule